// File: doc/BRIEF.md
# Quench Waveform Sequencer

This block drives the bias current DAC of a super-regenerative oscillator over one detection period of ten clock cycles. At the start of each period it captures a calibrated critical code. It then plays a fixed pattern of codes:

- four filter slots, one step below the critical code, where the oscillator acts as a high-Q bandpass filter;
- five ramp slots that rise past the critical code by offsets that double each slot;
- one off slot with code zero, which stops any oscillation before the next period begins.

During the ramp and off slots the block asserts a comparator-enable strobe. It counts the comparator ones it sees in that six-slot window. An early oscillator startup gives more ones, so the count measures received signal strength. One count comes out per period. At a 5 MHz system clock this gives 500 thousand results per second.

The strength result leaves as a single-cycle valid pulse. It has no ready input and cannot be held back, because the waveform is locked to the period. A consumer must accept each result in the cycle it appears. Enable, the critical code and the comparator bit are plain control inputs.

Top module: `quench_seq`

## Requirements
- R1: After reset the DAC code is 0, the strobe is low and the valid pulse is low.
- R2: In slots 1 to 4 of a period the DAC code equals the latched critical code minus one. A latched critical code of 0 gives 0.
- R3: In slots 5 to 9 the DAC code equals the latched critical code plus 1, 2, 4, 8 and 16 in that order.
- R4: In slot 10 the DAC code is 0.
- R5: The comparator strobe is high exactly in slots 5 to 10. Comparator ones outside those slots do not change the strength result.
- R6: The strength result equals the number of cycles in slots 5 to 10 in which the comparator bit was 1. Its range is 0 to 6, and counting restarts at zero for each period.
- R7: The valid pulse is high for exactly one cycle, the cycle after slot 10. The strength output holds the new result from that cycle until the next result.
- R8: While enable is low and no period is running, the DAC code is 0 and the strobe is low. Dropping enable mid-period lets the current period finish. A period starts on the cycle after enable is seen high in idle, and periods run back to back while enable stays high.
- R9: The critical code is sampled only when a period starts. Changes during a period do not affect that period's codes.
- R10: A ramp code whose sum exceeds 511 is held at 511.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Enable for periodic operation |
| crit_code | input | 9 | Calibrated critical bias code |
| cmp_bit | input | 1 | Oscillation comparator output |
| dac_code | output | 9 | Bias code to the current DAC |
| cmp_strobe | output | 1 | Comparator enable, high in slots 5 to 10 |
| strength | output | 3 | Count of comparator ones in the last period |
| strength_valid | output | 1 | One-cycle pulse marking a new strength |

## Verification
The assertions check on every cycle that the slot index stays in range and that the off slot drives zero. They also check that idle drives zero, that the strobe appears only in the comparator window, that the valid pulse follows the last slot, that the count never exceeds six, and that ramp codes never fall within a period. Only the bench scenarios can show the exact code values per slot, saturation near full scale, and the capture of the critical code at period start. The same holds for the strength count under different comparator patterns and for the finish-then-stop behaviour when enable drops mid-period. A behavioural model follows those scenarios cycle by cycle.

// File: rtl/quench_pkg.sv
package quench_pkg;
  localparam int CODE_W_D = 9;
  localparam int FILT_SLOTS_D = 4;
  localparam int RAMP_SLOTS_D = 5;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_FILT = 2'd1,
    PH_RAMP = 2'd2,
    PH_OFF  = 2'd3
  } phase_e;
endpackage

// File: rtl/quench_timer.sv
module quench_timer
  import quench_pkg::*;
#(
  parameter int FILT_SLOTS = FILT_SLOTS_D,
  parameter int RAMP_SLOTS = RAMP_SLOTS_D,
  localparam int PERIOD = FILT_SLOTS + RAMP_SLOTS + 1,
  localparam int SLOT_W = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  output logic [SLOT_W-1:0] slot,
  output phase_e            phase,
  output logic              period_start
);
  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(PERIOD - 1);
  localparam logic [SLOT_W-1:0] RAMP_FIRST = SLOT_W'(FILT_SLOTS);

  logic active;

  assign period_start = run_en && (!active || slot == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      slot   <= '0;
    end else if (period_start) begin
      active <= 1'b1;
      slot   <= '0;
    end else if (active && slot == LAST) begin
      active <= 1'b0;
      slot   <= '0;
    end else if (active) begin
      slot <= slot + 1'b1;
    end
  end

  always_comb begin
    if (!active)                phase = PH_IDLE;
    else if (slot < RAMP_FIRST) phase = PH_FILT;
    else if (slot == LAST)      phase = PH_OFF;
    else                        phase = PH_RAMP;
  end

  // R1
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST);
  // R8
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> slot == '0);
endmodule

// File: rtl/quench_code.sv
module quench_code
  import quench_pkg::*;
#(
  parameter int CODE_W = CODE_W_D,
  parameter int FILT_SLOTS = FILT_SLOTS_D,
  parameter int RAMP_SLOTS = RAMP_SLOTS_D,
  localparam int PERIOD = FILT_SLOTS + RAMP_SLOTS + 1,
  localparam int SLOT_W = $clog2(PERIOD)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_start,
  input  logic [CODE_W-1:0] crit_code,
  input  logic [SLOT_W-1:0] slot,
  input  phase_e            phase,
  output logic [CODE_W-1:0] dac_code
);
  logic [CODE_W-1:0] crit_q;
  logic [CODE_W-1:0] filt_code;
  logic [CODE_W-1:0] ramp_tab [RAMP_SLOTS];

  always_ff @(posedge clk) begin
    if (!rst_n)            crit_q <= '0;
    else if (period_start) crit_q <= crit_code;
  end

  assign filt_code = (crit_q == '0) ? '0 : crit_q - 1'b1;

  for (genvar k = 0; k < RAMP_SLOTS; k++) begin : g_ramp
    localparam logic [CODE_W:0] OFS = (CODE_W+1)'(1) << k;
    logic [CODE_W:0] sum;
    assign sum = {1'b0, crit_q} + OFS;
    assign ramp_tab[k] = sum[CODE_W] ? {CODE_W{1'b1}} : sum[CODE_W-1:0];
  end

  always_comb begin
    dac_code = '0;
    unique case (phase)
      PH_FILT: dac_code = filt_code;
      PH_RAMP: begin
        for (int k = 0; k < RAMP_SLOTS; k++)
          if (slot == SLOT_W'(FILT_SLOTS + k)) dac_code = ramp_tab[k];
      end
      default: dac_code = '0;
    endcase
  end

  // R3
  ramp_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RAMP && $past(phase) == PH_RAMP) |-> dac_code >= $past(dac_code));
endmodule

// File: rtl/quench_tally.sv
module quench_tally #(
  parameter int WIN = 6,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             window,
  input  logic             last_slot,
  input  logic             cmp_bit,
  output logic [CNT_W-1:0] strength,
  output logic             strength_valid
);
  logic [CNT_W-1:0] acc;
  logic             hit;

  assign hit = window && cmp_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc            <= '0;
      strength       <= '0;
      strength_valid <= 1'b0;
    end else if (last_slot) begin
      acc            <= '0;
      strength       <= acc + CNT_W'(hit);
      strength_valid <= 1'b1;
    end else begin
      acc            <= acc + CNT_W'(hit);
      strength_valid <= 1'b0;
    end
  end

  // R6
  count_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strength_valid |-> strength <= CNT_W'(WIN));
  // R7
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strength_valid |=> !strength_valid);
endmodule

// File: rtl/quench_seq.sv
module quench_seq
  import quench_pkg::*;
#(
  parameter int CODE_W = CODE_W_D,
  parameter int FILT_SLOTS = FILT_SLOTS_D,
  parameter int RAMP_SLOTS = RAMP_SLOTS_D,
  localparam int PERIOD = FILT_SLOTS + RAMP_SLOTS + 1,
  localparam int SLOT_W = $clog2(PERIOD),
  localparam int WIN = RAMP_SLOTS + 1,
  localparam int CNT_W = $clog2(WIN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic [CODE_W-1:0] crit_code,
  input  logic              cmp_bit,
  output logic [CODE_W-1:0] dac_code,
  output logic              cmp_strobe,
  output logic [CNT_W-1:0]  strength,
  output logic              strength_valid
);
  logic [SLOT_W-1:0] slot;
  phase_e            phase;
  logic              period_start;
  logic              last_slot;

  quench_timer #(.FILT_SLOTS(FILT_SLOTS), .RAMP_SLOTS(RAMP_SLOTS)) timer_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en),
    .slot(slot), .phase(phase), .period_start(period_start)
  );

  quench_code #(.CODE_W(CODE_W), .FILT_SLOTS(FILT_SLOTS), .RAMP_SLOTS(RAMP_SLOTS)) code_i (
    .clk(clk), .rst_n(rst_n), .period_start(period_start), .crit_code(crit_code),
    .slot(slot), .phase(phase), .dac_code(dac_code)
  );

  assign cmp_strobe = (phase == PH_RAMP) || (phase == PH_OFF);
  assign last_slot  = (phase == PH_OFF);

  quench_tally #(.WIN(WIN)) tally_i (
    .clk(clk), .rst_n(rst_n), .window(cmp_strobe), .last_slot(last_slot),
    .cmp_bit(cmp_bit), .strength(strength), .strength_valid(strength_valid)
  );

  // R4
  off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == SLOT_W'(PERIOD - 1)) |-> dac_code == '0);
  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (dac_code == '0 && !cmp_strobe));
  // R5
  strobe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_strobe |-> slot >= SLOT_W'(FILT_SLOTS));
  // R7
  valid_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strength_valid |-> $past(last_slot));
endmodule

// File: tb/quench_seq_tb_top.sv
module quench_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run_en = 1'b0;
  logic [8:0] crit_code = '0;
  logic       cmp_bit = 1'b0;
  logic [8:0] dac_code;
  logic       cmp_strobe;
  logic [2:0] strength;
  logic       strength_valid;

  always #4 clk = ~clk;

  quench_seq dut_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .crit_code(crit_code),
    .cmp_bit(cmp_bit), .dac_code(dac_code), .cmp_strobe(cmp_strobe),
    .strength(strength), .strength_valid(strength_valid)
  );

  int total = 0;
  int fails = 0;
  // reference model state
  int m_act = 0, m_slot = 0, m_crit = 0, m_cnt = 0, m_v = 0, m_s = 0;
  int mode = 0, thr = 0;
  logic [7:0] lfsr = 8'hA5;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_dac();
    int v;
    if (!m_act) return 0;
    if (m_slot < 4) return (m_crit == 0) ? 0 : m_crit - 1;
    if (m_slot == 9) return 0;
    v = m_crit + (1 << (m_slot - 4));
    return (v > 511) ? 511 : v;
  endfunction

  function automatic string dac_tag();
    if (!m_act) return "R8 idle dac";
    if (int'(crit_code) != m_crit) return "R9 latched crit dac";
    if (m_slot < 4) return "R2 filter dac";
    if (m_slot == 9) return "R4 off dac";
    if (m_crit + (1 << (m_slot - 4)) > 511) return "R10 saturated dac";
    return "R3 ramp dac";
  endfunction

  function automatic logic pick_cmp();
    case (mode)
      1: return 1'b1;
      2: return (m_act != 0 && m_slot >= thr);
      3: return lfsr[0];
      4: return (m_act == 0 || m_slot < 4);
      default: return 1'b0;
    endcase
  endfunction

  // one cycle: compare at negedge, drive inputs, advance model
  task automatic step(logic en, int crit);
    int win;
    check(dac_tag(), int'(dac_code), exp_dac());
    win = (m_act != 0 && m_slot >= 4) ? 1 : 0;
    check("R5 strobe", int'(cmp_strobe), win);
    check("R7 valid", int'(strength_valid), m_v);
    if (m_v) check("R6 strength", int'(strength), m_s);
    run_en = en;
    crit_code = 9'(crit);
    cmp_bit = pick_cmp();
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    // model next state
    if (m_act != 0 && m_slot == 9) begin
      m_v = 1; m_s = m_cnt + int'(cmp_bit); m_cnt = 0;
    end else begin
      m_v = 0;
      if (win) m_cnt += int'(cmp_bit);
    end
    if (en && (m_act == 0 || m_slot == 9)) begin
      m_act = 1; m_slot = 0; m_crit = crit;
    end else if (m_act != 0 && m_slot == 9) begin
      m_act = 0; m_slot = 0;
    end else if (m_act != 0) m_slot++;
    @(negedge clk);
  endtask

  task automatic run(int n, logic en, int crit);
    for (int i = 0; i < n; i++) step(en, crit);
  endtask

  initial begin
    #400000;
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset dac", int'(dac_code), 0);
    check("R1 reset strobe", int'(cmp_strobe), 0);
    check("R1 reset valid", int'(strength_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(3, 1'b0, 200);                       // R8 idle stays zero
    mode = 0; run(21, 1'b1, 200);            // no ones -> R6 count 0
    mode = 1; run(20, 1'b1, 200);            // all ones -> 6
    for (int t = 4; t <= 10; t++) begin      // startup at various slots
      mode = 2; thr = t; run(10, 1'b1, 300);
    end
    mode = 4; run(20, 1'b1, 100);            // R5 ones outside window ignored
    mode = 3; run(40, 1'b1, 37);             // pseudo-random pattern
    mode = 1; run(20, 1'b1, 0);              // R2 critical code zero
    run(20, 1'b1, 500);                      // R10 saturation
    run(10, 1'b1, 511);
    // R9 change critical code mid-period
    run(3, 1'b1, 150);
    run(4, 1'b1, 400);
    run(13, 1'b1, 20);
    // R8 drop enable mid-period: period completes, then idles
    run(4, 1'b1, 250);
    mode = 3; run(12, 1'b0, 250);
    run(25, 1'b1, 64);                       // restart from idle
    run(12, 1'b0, 64);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule